// File: doc/BRIEF.md
# Session Privilege Tracker

This block keeps the access rights of one secure-memory session. Pass/fail pulses arrive from the comparison logic outside the block. Each pulse reports one of two kinds of attempt. The first is a password attempt: a read or write password of one of eight password sets. The second is an authentication attempt using one of four key sets. The block also takes a pulse that requests stream encryption, a pulse that reports a MAC mismatch on an incoming command, and a pulse from the card reset line. From these it keeps five pieces of state: the one active password, the key set of the last good authentication, the session mode, and one consecutive-failure counter for each password set and each key set.

The session mode is a three-state machine. The states are `MODE_STD` (code 0), `MODE_AUTH` (code 1) and `MODE_ENC` (code 2). It has five named transitions. `T_AUTH_OK` goes from any state to `MODE_AUTH` on an accepted authentication success. `T_AUTH_FAIL` goes from any state to `MODE_STD` on an accepted authentication failure. `T_ENC_ON` goes from `MODE_AUTH` to `MODE_ENC` on an encryption request. `T_MAC_DROP` goes from `MODE_AUTH` or `MODE_ENC` to `MODE_STD` on a MAC mismatch. `T_SESS_RST` goes from any state to `MODE_STD` on the reset line. In every other case the state holds. Being authenticated is the same as being out of `MODE_STD`.

A second port group answers access queries for a memory zone. The caller presents the zone's password set, its key set and four requirement bits. The block returns `rd_ok` and `wr_ok` in the same cycle, computed from the registered session state. All state updates take effect at the clock edge that samples the pulse.

Top module: `sess_priv_tracker`

## Requirements
- R1: After `rst_n` is released, `mode` is 0 (`MODE_STD`), `pw_active` is 0, `auth_set` is 0, and every bit of `pw_lock` and `key_lock` is 0. A query with all four requirement bits at 0 returns `rd_ok`=`wr_ok`=1. Any query that needs a password, authentication or encryption returns 0.
- R2: An accepted password success on set s with type t (`pw_wr`=1 for a write password) makes `pw_active`=1, `pw_act_set`=s and `pw_act_wr`=t from the next cycle. It replaces any earlier password, and it clears the failure counter of set s.
- R3: An accepted password failure on set s clears `pw_active` from the next cycle and adds one to the failure counter of set s. Counters of other sets are unchanged.
- R4: When `q_rd_pw`=1, reading needs the active password to belong to set `q_pw_set`, and either a read or a write password satisfies it. When `q_wr_pw`=1, writing needs the active password to be a write password of set `q_pw_set`.
- R5: An accepted authentication success on key set k moves the mode to 1 (`MODE_AUTH`) and sets `auth_set`=k. This holds from any mode, including `MODE_ENC`.
- R6: An accepted authentication failure moves the mode to 0 (`MODE_STD`) and adds one to that key set's failure counter.
- R7: `enc_req` moves the mode from `MODE_AUTH` to 2 (`MODE_ENC`). In `MODE_STD` and in `MODE_ENC` it has no effect.
- R8: `mac_fail` in `MODE_AUTH` or `MODE_ENC` moves the mode to `MODE_STD`. In `MODE_STD` it has no effect.
- R9: `sess_rst` clears `pw_active` and moves the mode to `MODE_STD` from the next cycle. It leaves every failure counter and lock bit unchanged.
- R10: After MAX_TRIES (4) consecutive accepted failures on one set, that set's bit in `pw_lock` or `key_lock` is 1 and stays 1 until `rst_n`. Later pass or fail pulses for that set change no state, and the counter does not move.
- R11: When `q_auth`=1, both answers need a mode other than `MODE_STD` and `auth_set`=`q_key_set`. When `q_enc`=1, both answers need `MODE_ENC` and `auth_set`=`q_key_set`. `rd_ok` is the AND of the read password rule and these rules. `wr_ok` is the AND of the write password rule and these rules.
- R12: Pulses in the same cycle follow a fixed priority. `sess_rst` discards every other pulse in that cycle, including counter updates. A `mac_fail` that drops the mode discards an authentication attempt and `enc_req` in that cycle. An accepted authentication attempt overrides `enc_req`. Password attempts are independent of the mode pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of all state |
| sess_rst | input | 1 | Card reset line pulse; ends the session |
| pw_valid | input | 1 | Password check result present |
| pw_set | input | 3 | Password set of the attempt |
| pw_wr | input | 1 | 1 = write password, 0 = read password |
| pw_pass | input | 1 | 1 = comparison matched |
| au_valid | input | 1 | Authentication result present |
| au_set | input | 2 | Key set of the attempt |
| au_pass | input | 1 | 1 = authentication succeeded |
| enc_req | input | 1 | Request to enter encryption mode |
| mac_fail | input | 1 | MAC mismatch on an incoming command |
| q_pw_set | input | 3 | Zone query: password set guarding the zone |
| q_key_set | input | 2 | Zone query: key set assigned to the zone |
| q_rd_pw | input | 1 | Zone query: reading needs a password |
| q_wr_pw | input | 1 | Zone query: writing needs a write password |
| q_auth | input | 1 | Zone query: authentication required |
| q_enc | input | 1 | Zone query: encryption required |
| mode | output | 2 | Session mode: 0 standard, 1 authenticated, 2 encrypted |
| pw_active | output | 1 | A password is active |
| pw_act_set | output | 3 | Set of the active password |
| pw_act_wr | output | 1 | Active password is a write password |
| auth_set | output | 2 | Key set of the last successful authentication |
| pw_lock | output | 8 | Per password set: trial limit reached |
| key_lock | output | 4 | Per key set: trial limit reached |
| rd_ok | output | 1 | Zone query: read allowed |
| wr_ok | output | 1 | Zone query: write allowed |

## Verification
The assertions assume several things about the inputs. Each valid, request or failure signal is a single-cycle pulse. Set indices lie inside the configured number of sets. Query inputs are steady while `rd_ok` and `wr_ok` are read. The directed stimulus keeps to these rules by sending one operation at a time. The random phase places password, authentication, encryption, MAC and reset pulses in the same cycle, so that the priority of R12 is exercised. It draws indices only from the valid range, and it holds the query inputs still while it sweeps every query combination in chosen session states.

// File: rtl/sess_pkg.sv
`timescale 1ns/1ps
package sess_pkg;
    typedef enum logic [1:0] {
        MODE_STD  = 2'd0,
        MODE_AUTH = 2'd1,
        MODE_ENC  = 2'd2
    } sess_mode_e;
endpackage

// File: rtl/sess_trial_bank.sv
`timescale 1ns/1ps
// Per-set consecutive-failure counters with a trial limit.
module sess_trial_bank #(
    parameter int N_SETS    = 8,
    parameter int MAX_TRIES = 4,
    localparam int IDX_W    = (N_SETS > 1) ? $clog2(N_SETS) : 1,
    localparam int CNT_W    = $clog2(MAX_TRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              att_go,
    input  logic [IDX_W-1:0]  att_idx,
    input  logic              att_pass,
    output logic              accept,
    output logic [N_SETS-1:0] lock
);
    assign accept = att_go & ~lock[att_idx];

    for (genvar g = 0; g < N_SETS; g++) begin : g_set
        logic [CNT_W-1:0] fails;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fails <= '0;
            end else if (accept && (att_idx == IDX_W'(g))) begin
                if (att_pass) fails <= '0;
                else          fails <= fails + 1'b1;
            end
        end
        assign lock[g] = (fails == CNT_W'(MAX_TRIES));
    end
endmodule

// File: rtl/sess_pw_slot.sv
`timescale 1ns/1ps
// The single active password slot.
module sess_pw_slot #(
    parameter int N_PW_SETS = 8,
    localparam int IDX_W    = (N_PW_SETS > 1) ? $clog2(N_PW_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             go,
    input  logic [IDX_W-1:0] set_in,
    input  logic             wr_in,
    input  logic             pass,
    output logic             active,
    output logic [IDX_W-1:0] act_set,
    output logic             act_wr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active  <= 1'b0;
            act_set <= '0;
            act_wr  <= 1'b0;
        end else if (clr) begin
            active  <= 1'b0;
        end else if (go) begin
            if (pass) begin
                active  <= 1'b1;
                act_set <= set_in;
                act_wr  <= wr_in;
            end else begin
                active  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sess_mode_fsm.sv
`timescale 1ns/1ps
// Session mode machine: standard / authenticated / encrypted.
module sess_mode_fsm
    import sess_pkg::*;
#(
    parameter int N_KEY_SETS = 4,
    localparam int KEY_W     = (N_KEY_SETS > 1) ? $clog2(N_KEY_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sess_rst,
    input  logic             mac_fail,
    input  logic             au_go,
    input  logic [KEY_W-1:0] au_set,
    input  logic             au_pass,
    input  logic             enc_req,
    output sess_mode_e       mode_o,
    output logic [KEY_W-1:0] auth_set
);
    sess_mode_e       st, st_nxt;
    logic [KEY_W-1:0] set_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= MODE_STD;
            auth_set <= '0;
        end else begin
            st       <= st_nxt;
            auth_set <= set_nxt;
        end
    end

    always_comb begin
        st_nxt  = st;
        set_nxt = auth_set;
        if (sess_rst) begin
            st_nxt = MODE_STD;                         // T_SESS_RST
        end else if (mac_fail && (st != MODE_STD)) begin
            st_nxt = MODE_STD;                         // T_MAC_DROP
        end else if (au_go) begin
            if (au_pass) begin
                st_nxt  = MODE_AUTH;                   // T_AUTH_OK
                set_nxt = au_set;
            end else begin
                st_nxt  = MODE_STD;                    // T_AUTH_FAIL
            end
        end else begin
            unique case (st)
                MODE_STD:  st_nxt = MODE_STD;
                MODE_AUTH: st_nxt = enc_req ? MODE_ENC : MODE_AUTH;  // T_ENC_ON
                MODE_ENC:  st_nxt = MODE_ENC;
                default:   st_nxt = MODE_STD;
            endcase
        end
    end

    always_comb begin
        mode_o = st;
    end
endmodule

// File: rtl/sess_access_eval.sv
`timescale 1ns/1ps
// Combinational zone access decision.
module sess_access_eval
    import sess_pkg::*;
#(
    parameter int N_PW_SETS  = 8,
    parameter int N_KEY_SETS = 4,
    localparam int PW_W      = (N_PW_SETS > 1) ? $clog2(N_PW_SETS) : 1,
    localparam int KEY_W     = (N_KEY_SETS > 1) ? $clog2(N_KEY_SETS) : 1
) (
    input  sess_mode_e       mode,
    input  logic             pw_active,
    input  logic [PW_W-1:0]  pw_act_set,
    input  logic             pw_act_wr,
    input  logic [KEY_W-1:0] auth_set,
    input  logic [PW_W-1:0]  q_pw_set,
    input  logic [KEY_W-1:0] q_key_set,
    input  logic             q_rd_pw,
    input  logic             q_wr_pw,
    input  logic             q_auth,
    input  logic             q_enc,
    output logic             rd_ok,
    output logic             wr_ok
);
    logic pw_match, key_match, rd_pw_ok, wr_pw_ok, auth_ok, enc_ok;

    always_comb begin
        pw_match  = pw_active && (pw_act_set == q_pw_set);
        key_match = (auth_set == q_key_set);
        rd_pw_ok  = !q_rd_pw || pw_match;
        wr_pw_ok  = !q_wr_pw || (pw_match && pw_act_wr);
        auth_ok   = !q_auth  || ((mode != MODE_STD) && key_match);
        enc_ok    = !q_enc   || ((mode == MODE_ENC) && key_match);
        rd_ok     = rd_pw_ok && auth_ok && enc_ok;
        wr_ok     = wr_pw_ok && auth_ok && enc_ok;
    end
endmodule

// File: rtl/sess_priv_tracker.sv
`timescale 1ns/1ps
// Top: session privilege tracker.
module sess_priv_tracker
    import sess_pkg::*;
#(
    parameter int N_PW_SETS  = 8,
    parameter int N_KEY_SETS = 4,
    parameter int MAX_TRIES  = 4,
    localparam int PW_W      = (N_PW_SETS > 1) ? $clog2(N_PW_SETS) : 1,
    localparam int KEY_W     = (N_KEY_SETS > 1) ? $clog2(N_KEY_SETS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sess_rst,
    input  logic                  pw_valid,
    input  logic [PW_W-1:0]       pw_set,
    input  logic                  pw_wr,
    input  logic                  pw_pass,
    input  logic                  au_valid,
    input  logic [KEY_W-1:0]      au_set,
    input  logic                  au_pass,
    input  logic                  enc_req,
    input  logic                  mac_fail,
    input  logic [PW_W-1:0]       q_pw_set,
    input  logic [KEY_W-1:0]      q_key_set,
    input  logic                  q_rd_pw,
    input  logic                  q_wr_pw,
    input  logic                  q_auth,
    input  logic                  q_enc,
    output logic [1:0]            mode,
    output logic                  pw_active,
    output logic [PW_W-1:0]       pw_act_set,
    output logic                  pw_act_wr,
    output logic [KEY_W-1:0]      auth_set,
    output logic [N_PW_SETS-1:0]  pw_lock,
    output logic [N_KEY_SETS-1:0] key_lock,
    output logic                  rd_ok,
    output logic                  wr_ok
);
    sess_mode_e mode_q;
    logic       pw_go, pw_acc, au_go, au_acc, mac_drop;

    assign mac_drop = mac_fail && (mode_q != MODE_STD);
    assign pw_go    = pw_valid && !sess_rst;
    assign au_go    = au_valid && !sess_rst && !mac_drop;
    assign mode     = mode_q;

    sess_trial_bank #(.N_SETS(N_PW_SETS), .MAX_TRIES(MAX_TRIES)) pw_bank_i (
        .clk(clk), .rst_n(rst_n), .att_go(pw_go), .att_idx(pw_set),
        .att_pass(pw_pass), .accept(pw_acc), .lock(pw_lock)
    );

    sess_trial_bank #(.N_SETS(N_KEY_SETS), .MAX_TRIES(MAX_TRIES)) key_bank_i (
        .clk(clk), .rst_n(rst_n), .att_go(au_go), .att_idx(au_set),
        .att_pass(au_pass), .accept(au_acc), .lock(key_lock)
    );

    sess_pw_slot #(.N_PW_SETS(N_PW_SETS)) slot_i (
        .clk(clk), .rst_n(rst_n), .clr(sess_rst), .go(pw_acc),
        .set_in(pw_set), .wr_in(pw_wr), .pass(pw_pass),
        .active(pw_active), .act_set(pw_act_set), .act_wr(pw_act_wr)
    );

    sess_mode_fsm #(.N_KEY_SETS(N_KEY_SETS)) fsm_i (
        .clk(clk), .rst_n(rst_n), .sess_rst(sess_rst), .mac_fail(mac_fail),
        .au_go(au_acc), .au_set(au_set), .au_pass(au_pass), .enc_req(enc_req),
        .mode_o(mode_q), .auth_set(auth_set)
    );

    sess_access_eval #(.N_PW_SETS(N_PW_SETS), .N_KEY_SETS(N_KEY_SETS)) eval_i (
        .mode(mode_q), .pw_active(pw_active), .pw_act_set(pw_act_set),
        .pw_act_wr(pw_act_wr), .auth_set(auth_set), .q_pw_set(q_pw_set),
        .q_key_set(q_key_set), .q_rd_pw(q_rd_pw), .q_wr_pw(q_wr_pw),
        .q_auth(q_auth), .q_enc(q_enc), .rd_ok(rd_ok), .wr_ok(wr_ok)
    );
endmodule

// File: rtl/sess_priv_chk.sv
`timescale 1ns/1ps
// Property checker bound to the tracker.
module sess_priv_chk #(
    parameter int N_PW_SETS  = 8,
    parameter int N_KEY_SETS = 4,
    localparam int PW_W      = (N_PW_SETS > 1) ? $clog2(N_PW_SETS) : 1,
    localparam int KEY_W     = (N_KEY_SETS > 1) ? $clog2(N_KEY_SETS) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sess_rst,
    input logic                  pw_valid,
    input logic [PW_W-1:0]       pw_set,
    input logic                  pw_wr,
    input logic                  pw_pass,
    input logic                  au_valid,
    input logic [KEY_W-1:0]      au_set,
    input logic                  au_pass,
    input logic                  enc_req,
    input logic                  mac_fail,
    input logic [PW_W-1:0]       q_pw_set,
    input logic [KEY_W-1:0]      q_key_set,
    input logic                  q_rd_pw,
    input logic                  q_wr_pw,
    input logic                  q_auth,
    input logic                  q_enc,
    input logic [1:0]            mode,
    input logic                  pw_active,
    input logic [PW_W-1:0]       pw_act_set,
    input logic                  pw_act_wr,
    input logic [KEY_W-1:0]      auth_set,
    input logic [N_PW_SETS-1:0]  pw_lock,
    input logic [N_KEY_SETS-1:0] key_lock,
    input logic                  rd_ok,
    input logic                  wr_ok
);
    AST_PW_ACTIVATE: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_valid && pw_pass && !pw_lock[pw_set] && !sess_rst)
        |=> (pw_active && pw_act_set == $past(pw_set) && pw_act_wr == $past(pw_wr))); // R2

    AST_PW_FAIL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_valid && !pw_pass && !pw_lock[pw_set]) |=> !pw_active); // R3

    AST_ENC_FROM_AUTH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && $past(mode) != 2'd2) |-> ($past(mode) == 2'd1 && $past(enc_req))); // R7

    AST_MAC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_fail && mode != 2'd0) |=> (mode == 2'd0)); // R8

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sess_rst |=> (mode == 2'd0 && !pw_active)); // R9

    AST_SRST_KEEPS_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        sess_rst |=> ($stable(pw_lock) && $stable(key_lock))); // R9

    AST_PW_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pw_lock) & ~pw_lock) == '0)); // R10

    AST_KEY_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(key_lock) & ~key_lock) == '0)); // R10

    AST_LOCKED_PW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_valid && pw_lock[pw_set] && !sess_rst)
        |=> (pw_active == $past(pw_active) && pw_act_set == $past(pw_act_set))); // R10

    AST_ENC_NEEDS_ENC_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (q_enc && rd_ok) |-> (mode == 2'd2)); // R11

    always_comb begin
        if (rst_n && q_rd_pw && q_wr_pw && wr_ok)
            AST_WR_GRANTS_RD: assert (rd_ok); // R4
    end
endmodule

bind sess_priv_tracker sess_priv_chk #(
    .N_PW_SETS(N_PW_SETS), .N_KEY_SETS(N_KEY_SETS)
) chk_i (.*);

// File: tb/sess_priv_tracker_tb.sv
`timescale 1ns/1ps
module sess_priv_tracker_tb_top;
    localparam int NP = 8;
    localparam int NK = 4;
    localparam int MT = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, sess_rst, pw_valid, pw_wr, pw_pass, au_valid, au_pass, enc_req, mac_fail;
    logic [2:0] pw_set, q_pw_set, pw_act_set;
    logic [1:0] au_set, q_key_set, mode, auth_set;
    logic       q_rd_pw, q_wr_pw, q_auth, q_enc, pw_active, pw_act_wr, rd_ok, wr_ok;
    logic [7:0] pw_lock;
    logic [3:0] key_lock;

    sess_priv_tracker dut_i (.*);

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int e_mode, e_pa, e_pset, e_pwr, e_aset;
    int pcnt[NP];
    int kcnt[NK];

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        e_mode = 0; e_pa = 0; e_pset = 0; e_pwr = 0; e_aset = 0;
        for (int i = 0; i < NP; i++) pcnt[i] = 0;
        for (int i = 0; i < NK; i++) kcnt[i] = 0;
    endtask

    function automatic int exp_plock();
        int v = 0;
        for (int i = 0; i < NP; i++) if (pcnt[i] == MT) v |= (1 << i);
        return v;
    endfunction

    function automatic int exp_klock();
        int v = 0;
        for (int i = 0; i < NK; i++) if (kcnt[i] == MT) v |= (1 << i);
        return v;
    endfunction

    task automatic chk_state(string tag);
        chk(int'(mode) == e_mode, {tag, " mode"}, int'(mode), e_mode);
        chk(int'(pw_active) == e_pa, {tag, " pw_active"}, int'(pw_active), e_pa);
        if (e_pa != 0) begin
            chk(int'(pw_act_set) == e_pset, {tag, " pw_act_set"}, int'(pw_act_set), e_pset);
            chk(int'(pw_act_wr) == e_pwr, {tag, " pw_act_wr"}, int'(pw_act_wr), e_pwr);
        end
        chk(int'(auth_set) == e_aset, {tag, " auth_set"}, int'(auth_set), e_aset);
        chk(int'(pw_lock) == exp_plock(), {tag, " pw_lock"}, int'(pw_lock), exp_plock());
        chk(int'(key_lock) == exp_klock(), {tag, " key_lock"}, int'(key_lock), exp_klock());
    endtask

    task automatic idle_inputs();
        sess_rst = 0; pw_valid = 0; pw_set = 0; pw_wr = 0; pw_pass = 0;
        au_valid = 0; au_set = 0; au_pass = 0; enc_req = 0; mac_fail = 0;
    endtask

    // One operation: drive at a falling edge, model it, outputs settle by next falling edge.
    task automatic op(int sr, int pv, int ps, int pw, int pp, int av, int as, int ap, int en, int mf);
        @(negedge clk);
        sess_rst = 1'(sr); pw_valid = 1'(pv); pw_set = 3'(ps); pw_wr = 1'(pw); pw_pass = 1'(pp);
        au_valid = 1'(av); au_set = 2'(as); au_pass = 1'(ap); enc_req = 1'(en); mac_fail = 1'(mf);
        if (sr != 0) begin
            e_pa = 0; e_mode = 0;
        end else begin
            if (pv != 0 && pcnt[ps] < MT) begin
                if (pp != 0) begin e_pa = 1; e_pset = ps; e_pwr = pw; pcnt[ps] = 0; end
                else begin e_pa = 0; pcnt[ps]++; end
            end
            if (mf != 0 && e_mode != 0) begin
                e_mode = 0;
            end else if (av != 0 && kcnt[as] < MT) begin
                if (ap != 0) begin e_mode = 1; e_aset = as; kcnt[as] = 0; end
                else begin e_mode = 0; kcnt[as]++; end
            end else if (en != 0 && e_mode == 1) begin
                e_mode = 2;
            end
        end
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic pw_op(int s, int w, int p); op(0, 1, s, w, p, 0, 0, 0, 0, 0); endtask
    task automatic au_op(int k, int p); op(0, 0, 0, 0, 0, 1, k, p, 0, 0); endtask

    // Exhaustive sweep of all query inputs against the current session state.
    task automatic sweep(string tag);
        for (int ps = 0; ps < NP; ps++)
            for (int ks = 0; ks < NK; ks++)
                for (int b = 0; b < 16; b++) begin
                    int pm, km, rdp, wrp, au, en, erd, ewr;
                    q_pw_set = 3'(ps); q_key_set = 2'(ks);
                    q_rd_pw = b[0]; q_wr_pw = b[1]; q_auth = b[2]; q_enc = b[3];
                    #1;
                    pm  = (e_pa != 0 && e_pset == ps) ? 1 : 0;
                    km  = (e_aset == ks) ? 1 : 0;
                    rdp = (b[0] == 0 || pm != 0) ? 1 : 0;
                    wrp = (b[1] == 0 || (pm != 0 && e_pwr != 0)) ? 1 : 0;
                    au  = (b[2] == 0 || (e_mode != 0 && km != 0)) ? 1 : 0;
                    en  = (b[3] == 0 || (e_mode == 2 && km != 0)) ? 1 : 0;
                    erd = rdp & au & en;
                    ewr = wrp & au & en;
                    chk(int'(rd_ok) == erd, {tag, " R11 rd_ok"}, int'(rd_ok), erd);
                    chk(int'(wr_ok) == ewr, {tag, " R11 wr_ok"}, int'(wr_ok), ewr);
                end
        q_rd_pw = 0; q_wr_pw = 0; q_auth = 0; q_enc = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();
        @(negedge clk);
    endtask

    initial begin
        q_pw_set = 0; q_key_set = 0; q_rd_pw = 0; q_wr_pw = 0; q_auth = 0; q_enc = 0;
        do_reset();
        chk_state("R1 reset");
        sweep("R1 reset query");

        pw_op(3, 0, 1);  chk_state("R2 read pw set3");
        sweep("R4 read pw only");
        pw_op(5, 1, 1);  chk_state("R2 replace with write pw set5");
        sweep("R4 write pw grants read");
        pw_op(5, 1, 0);  chk_state("R3 fail clears active");
        for (int i = 0; i < 3; i++) pw_op(5, 0, 0);
        chk_state("R10 set5 locked after four fails");
        pw_op(2, 1, 1);
        pw_op(5, 1, 1);  chk_state("R10 locked set5 pass ignored");
        pw_op(5, 0, 0);  chk_state("R10 locked set5 fail ignored");
        for (int i = 0; i < 3; i++) pw_op(1, 0, 0);
        pw_op(1, 0, 1);
        for (int i = 0; i < 3; i++) pw_op(1, 0, 0);
        chk_state("R2 success clears counter set1");

        au_op(2, 1);     chk_state("R5 auth key2");
        op(0, 0, 0, 0, 0, 0, 0, 0, 1, 0); chk_state("R7 enc on");
        sweep("R11 encrypted session");
        au_op(1, 1);     chk_state("R5 reauth from enc");
        op(0, 0, 0, 0, 0, 0, 0, 0, 0, 1); chk_state("R8 mac drop");
        op(0, 0, 0, 0, 0, 0, 0, 0, 0, 1); chk_state("R8 mac in std ignored");
        op(0, 0, 0, 0, 0, 0, 0, 0, 1, 0); chk_state("R7 enc in std ignored");
        au_op(1, 1);
        op(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        au_op(0, 0);     chk_state("R6 auth fail drops to std");
        au_op(1, 1);     sweep("R11 authenticated session");
        pw_op(4, 1, 1);
        op(1, 0, 0, 0, 0, 0, 0, 0, 0, 0); chk_state("R9 sess_rst clears, keeps locks");
        op(1, 1, 6, 1, 1, 1, 3, 1, 0, 0); chk_state("R12 sess_rst discards same-cycle attempts");
        au_op(0, 1);
        op(0, 0, 0, 0, 0, 1, 2, 1, 0, 1); chk_state("R12 mac drop beats auth");
        au_op(0, 1);
        op(0, 0, 0, 0, 0, 1, 3, 1, 1, 0); chk_state("R12 auth beats enc");
        for (int i = 0; i < 4; i++) au_op(2, 0);
        chk_state("R10 key2 locked");
        au_op(2, 1);     chk_state("R10 locked key2 pass ignored");

        // Random phase: combined pulses, model-predicted state after every operation.
        do_reset();
        chk_state("R1 second reset");
        for (int n = 0; n < 1500; n++) begin
            int sr, pv, av, en, mf;
            sr = ($urandom_range(31) == 0) ? 1 : 0;
            pv = ($urandom_range(1) == 0) ? 1 : 0;
            av = ($urandom_range(2) == 0) ? 1 : 0;
            en = ($urandom_range(3) == 0) ? 1 : 0;
            mf = ($urandom_range(7) == 0) ? 1 : 0;
            op(sr, pv, $urandom_range(NP - 1), $urandom_range(1), ($urandom_range(2) == 0) ? 1 : 0,
               av, $urandom_range(NK - 1), ($urandom_range(2) != 0) ? 1 : 0, en, mf);
            chk_state("R12 random mix");
            if (n % 250 == 0) sweep("R11 random state");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule